// File: doc/BRIEF.md
# Cycle-Timed Event Scheduler

This block keeps up to 32 pending events and releases each one on the bus-clock cycle it was booked for. Every event carries a source identifier and a payload. A free-running 32-bit cycle counter advances by one on every clock. On each cycle the stored entries are compared with the counter. An entry that matches is emitted on the fire outputs for one cycle, and its slot is released.

A client books an event through a valid/ready port, giving a source, a payload and a delay measured from the current count. Before it stores the request, the block makes sure that no other stored event holds the same cycle. If the cycle is taken, the request slides forward one cycle per clock until it finds a free cycle. An entry that is already stored never moves. A new booking from a source that already has an entry pending overwrites that entry. A separate cancel input removes the pending entry of a given source. When every slot holds an entry and the request comes from a source with nothing pending, the request is refused and a sticky flag records the loss.

Top module: `evt_sched`

## Requirements
- R1: `cycle_count` is 0 in the first cycle after reset is released and grows by exactly 1 on every clock, wrapping modulo 2^32.
- R2: `req_ready` is high whenever the block is not resolving a request. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the request has been stored or refused, and it is high again in the cycle after that.
- R3: The booked fire cycle is the `cycle_count` of the cycle after acceptance plus the delay. A delay of 0 counts as 1.
- R4: When a stored entry's fire cycle equals `cycle_count`, `fire_valid` is high for one cycle in the following cycle, and `fire_src` and `fire_payload` carry that entry's fields. The entry is then released.
- R5: If another source's stored entry holds the candidate cycle, the candidate goes up by 1 on each clock until it is free. Entries already stored keep their cycles.
- R6: A request from a source with a pending entry overwrites that entry in place: the old payload and cycle never fire, and no extra slot is used, even when all 32 slots are occupied.
- R7: With all 32 slots occupied and no pending entry for the requesting source, the request is dropped, `overflow` rises and stays high until reset, and every stored entry still fires on its cycle.
- R8: A cycle with `cancel_valid` high removes the pending entry of `cancel_src` at the end of that cycle, so it never fires later.
- R9: At most one event fires in any cycle, because no two stored entries share a fire cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Booking request present |
| req_ready | output | 1 | Block can take a booking this cycle |
| req_src | input | 6 | Source identifier of the booking |
| req_payload | input | 8 | Payload delivered when the event fires |
| req_delay | input | 16 | Cycles from now until firing (0 counts as 1) |
| cancel_valid | input | 1 | Remove the pending entry of `cancel_src` |
| cancel_src | input | 6 | Source whose entry is removed |
| fire_valid | output | 1 | One-cycle pulse: an event is due |
| fire_src | output | 6 | Source of the firing event |
| fire_payload | output | 8 | Payload of the firing event |
| overflow | output | 1 | Sticky: a booking was dropped because the queue was full |
| cycle_count | output | 32 | Free-running bus-cycle counter |

## Verification
The bench books three sources onto one cycle. A design that bumped the older entry, or that stored two entries on one cycle, would fire out of order or drop a pulse. Other directed cases cover a zero delay, which would never fire or would fire at once if handled wrongly, and a replacement that must not leave a stale second firing behind. A cancel is checked to stop its event from firing later. With the queue full, a same-source rebook must still go through and an extra source must be dropped without harming the stored entries. A long random run also mixes cancels with bookings that land in the same cycle as a due entry of the same source.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEEK = 1'b1
  } seek_state_e;
endpackage

// File: rtl/evt_first_set.sv
module evt_first_set #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/evt_slot_table.sv
module evt_slot_table #(
  parameter int SLOTS = 32,
  parameter int SRC_W = 6,
  parameter int PAY_W = 8,
  parameter int CNT_W = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now,
  input  logic [CNT_W-1:0] probe_cyc,
  input  logic [SRC_W-1:0] probe_src,
  input  logic             kill_valid,
  input  logic [SRC_W-1:0] kill_src,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [PAY_W-1:0] wr_pay,
  input  logic [CNT_W-1:0] wr_cyc,
  output logic [SLOTS-1:0] valid_vec,
  output logic [SLOTS-1:0] due_vec,
  output logic [SLOTS-1:0] coll_vec,
  output logic [SLOTS-1:0] same_vec,
  output logic [SRC_W-1:0] due_src,
  output logic [PAY_W-1:0] due_pay
);
  logic [SRC_W-1:0] src_q [SLOTS];
  logic [PAY_W-1:0] pay_q [SLOTS];
  logic [CNT_W-1:0] cyc_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_wr;
    logic hit_kill;
    assign hit_wr      = wr_en && (wr_idx == IDX_W'(g));
    assign hit_kill    = kill_valid && valid_vec[g] && (src_q[g] == kill_src);
    assign due_vec[g]  = valid_vec[g] && (cyc_q[g] == now);
    assign same_vec[g] = valid_vec[g] && (src_q[g] == probe_src);
    assign coll_vec[g] = valid_vec[g] && (cyc_q[g] == probe_cyc) && (src_q[g] != probe_src);

    // write beats fire and cancel on the same edge
    always_ff @(posedge clk) begin
      if (!rst_n) valid_vec[g] <= 1'b0;
      else if (hit_wr) valid_vec[g] <= 1'b1;
      else if (due_vec[g] || hit_kill) valid_vec[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        src_q[g] <= wr_src;
        pay_q[g] <= wr_pay;
        cyc_q[g] <= wr_cyc;
      end
    end
  end

  // due_vec is one-hot or zero, so an OR mux is enough
  always_comb begin
    due_src = '0;
    due_pay = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (due_vec[i]) begin
        due_src = due_src | src_q[i];
        due_pay = due_pay | pay_q[i];
      end
    end
  end
endmodule

// File: rtl/evt_sched.sv
module evt_sched #(
  parameter int SLOTS = 32,
  parameter int SRC_W = 6,
  parameter int PAY_W = 8,
  parameter int CNT_W = 32,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic [PAY_W-1:0] req_payload,
  input  logic [DLY_W-1:0] req_delay,
  input  logic             cancel_valid,
  input  logic [SRC_W-1:0] cancel_src,
  output logic             fire_valid,
  output logic [SRC_W-1:0] fire_src,
  output logic [PAY_W-1:0] fire_payload,
  output logic             overflow,
  output logic [CNT_W-1:0] cycle_count
);
  import evt_sched_pkg::*;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // first candidate: count of the next cycle plus the delay, a zero delay taken as one
  function automatic logic [CNT_W-1:0] first_target(input logic [CNT_W-1:0] now,
                                                     input logic [DLY_W-1:0] dly);
    logic [CNT_W-1:0] eff;
    eff = (dly == '0) ? CNT_W'(1) : CNT_W'(dly);
    return now + CNT_W'(1) + eff;
  endfunction

  seek_state_e      state;
  logic [SRC_W-1:0] seek_src;
  logic [PAY_W-1:0] seek_pay;
  logic [CNT_W-1:0] seek_cyc;

  logic [SLOTS-1:0] valid_vec, due_vec, coll_vec, same_vec;
  logic [SRC_W-1:0] due_src;
  logic [PAY_W-1:0] due_pay;
  logic             due_any, coll_any, same_any, free_any;
  logic [IDX_W-1:0] due_idx, same_idx, free_idx, wr_idx;
  logic             seeking, accept_en, commit_en, refuse_en;

  assign seeking   = (state == ST_SEEK);
  assign req_ready = !seeking;
  assign accept_en = req_valid && req_ready;
  assign coll_any  = |coll_vec;
  assign commit_en = seeking && !coll_any && (same_any || free_any);
  assign refuse_en = seeking && !coll_any && !same_any && !free_any;
  assign wr_idx    = same_any ? same_idx : free_idx;

  evt_slot_table #(
    .SLOTS(SLOTS), .SRC_W(SRC_W), .PAY_W(PAY_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .now(cycle_count),
    .probe_cyc(seek_cyc), .probe_src(seek_src),
    .kill_valid(cancel_valid), .kill_src(cancel_src),
    .wr_en(commit_en), .wr_idx(wr_idx), .wr_src(seek_src), .wr_pay(seek_pay), .wr_cyc(seek_cyc),
    .valid_vec(valid_vec), .due_vec(due_vec), .coll_vec(coll_vec), .same_vec(same_vec),
    .due_src(due_src), .due_pay(due_pay)
  );

  evt_first_set #(.N(SLOTS), .IDX_W(IDX_W)) u_due  (.vec(due_vec),    .any(due_any),  .idx(due_idx));
  evt_first_set #(.N(SLOTS), .IDX_W(IDX_W)) u_same (.vec(same_vec),   .any(same_any), .idx(same_idx));
  evt_first_set #(.N(SLOTS), .IDX_W(IDX_W)) u_free (.vec(~valid_vec), .any(free_any), .idx(free_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_count <= '0;
      state       <= ST_IDLE;
      seek_src    <= '0;
      seek_pay    <= '0;
      seek_cyc    <= '0;
      overflow    <= 1'b0;
    end else begin
      cycle_count <= cycle_count + CNT_W'(1);
      if (accept_en) begin
        state    <= ST_SEEK;
        seek_src <= req_src;
        seek_pay <= req_payload;
        seek_cyc <= first_target(cycle_count, req_delay);
      end else if (seeking) begin
        if (coll_any) seek_cyc <= seek_cyc + CNT_W'(1);
        else state <= ST_IDLE;
      end
      if (refuse_en) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_valid   <= 1'b0;
      fire_src     <= '0;
      fire_payload <= '0;
    end else begin
      fire_valid <= due_any;
      if (due_any) begin
        fire_src     <= due_src;
        fire_payload <= due_pay;
      end
    end
  end
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int SLOTS = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             seeking,
  input logic             coll_any,
  input logic [CNT_W-1:0] seek_cyc,
  input logic [SLOTS-1:0] due_vec,
  input logic [SLOTS-1:0] valid_vec,
  input logic             due_any,
  input logic             fire_valid,
  input logic             refuse_en,
  input logic             overflow,
  input logic [CNT_W-1:0] cycle_count
);
  // R1: counter steps by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cycle_count == $past(cycle_count) + CNT_W'(1));

  // R2: no booking taken while one is being resolved
  p_seek_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seeking |-> !req_ready);

  // R4: a due entry produces a fire pulse next cycle
  p_due_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    due_any |=> fire_valid);

  // R5: a taken candidate slides forward by exactly one
  p_bump_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seeking && coll_any |=> seeking && seek_cyc == $past(seek_cyc) + CNT_W'(1));

  // R7: refusal happens only with every slot occupied
  p_refuse_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_en |-> &valid_vec);

  // R7: refusal raises the flag
  p_refuse_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_en |=> overflow);

  // R7: flag is sticky
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: never two entries due together
  p_one_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(due_vec));
endmodule

bind evt_sched evt_sched_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .seeking(seeking),
  .coll_any(coll_any), .seek_cyc(seek_cyc), .due_vec(due_vec), .valid_vec(valid_vec),
  .due_any(due_any), .fire_valid(fire_valid), .refuse_en(refuse_en),
  .overflow(overflow), .cycle_count(cycle_count)
);

// File: tb/tb_evt_sched.sv
module tb_evt_sched;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SLOTS = 32;
  localparam int NSRC  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_src = '0;
  logic [7:0]  req_payload = '0;
  logic [15:0] req_delay = '0;
  logic        cancel_valid = 1'b0;
  logic [5:0]  cancel_src = '0;
  logic        fire_valid;
  logic [5:0]  fire_src;
  logic [7:0]  fire_payload;
  logic        overflow;
  logic [31:0] cycle_count;

  always #2.5 clk = ~clk;

  evt_sched dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_payload(req_payload), .req_delay(req_delay),
    .cancel_valid(cancel_valid), .cancel_src(cancel_src),
    .fire_valid(fire_valid), .fire_src(fire_src), .fire_payload(fire_payload),
    .overflow(overflow), .cycle_count(cycle_count)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  bit          mv [SLOTS];
  logic [31:0] mt [SLOTS];
  int          ms [SLOTS];
  int          mp [SLOTS];
  logic [31:0] mcnt;
  bit          mseek, movf, efv;
  int          lsrc, lpay, efs, efp;
  logic [31:0] lcand;

  int          obs_n   [NSRC];
  logic [31:0] obs_at  [NSRC];
  int          obs_pay [NSRC];

  function automatic logic [31:0] book_cycle(input logic [31:0] acc, input int dly);
    return acc + 32'd1 + ((dly == 0) ? 32'd1 : 32'(dly));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at count %0d", tag, act, exp, cycle_count);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) mv[i] = 1'b0;
    mcnt = '0; mseek = 1'b0; movf = 1'b0; efv = 1'b0;
  endtask

  task automatic model_step();
    bit pv [SLOTS];
    int fi;
    fi = -1;
    for (int i = 0; i < SLOTS; i++) begin
      pv[i] = mv[i];
      if (mv[i] && mt[i] == mcnt) fi = i;
    end
    efv = (fi >= 0);
    if (efv) begin efs = ms[fi]; efp = mp[fi]; mv[fi] = 1'b0; end
    if (cancel_valid)
      for (int i = 0; i < SLOTS; i++) if (pv[i] && ms[i] == int'(cancel_src)) mv[i] = 1'b0;
    if (mseek) begin
      bit coll;
      int same, free, slot;
      coll = 1'b0; same = -1; free = -1;
      for (int i = 0; i < SLOTS; i++) begin
        if (pv[i] && mt[i] == lcand && ms[i] != lsrc) coll = 1'b1;
        if (pv[i] && ms[i] == lsrc) same = i;
        if (!pv[i] && free < 0) free = i;
      end
      if (coll) lcand = lcand + 32'd1;
      else begin
        slot = (same >= 0) ? same : free;
        if (slot < 0) movf = 1'b1;
        else begin mv[slot] = 1'b1; mt[slot] = lcand; ms[slot] = lsrc; mp[slot] = lpay; end
        mseek = 1'b0;
      end
    end else if (req_valid) begin
      lsrc = int'(req_src); lpay = int'(req_payload);
      lcand = book_cycle(mcnt, int'(req_delay));
      mseek = 1'b1;
    end
    mcnt = mcnt + 32'd1;
  endtask

  task automatic compare();
    chk("R1 cycle_count", cycle_count, mcnt);
    chk("R2 req_ready", req_ready, !mseek);
    chk("R4 fire_valid", fire_valid, efv);
    if (efv && fire_valid) begin
      chk("R4 fire_src", fire_src, efs);
      chk("R4 fire_payload", fire_payload, efp);
    end
    chk("R7 overflow", overflow, movf);
    if (fire_valid) begin
      obs_n[fire_src]++;
      obs_at[fire_src] = cycle_count;
      obs_pay[fire_src] = int'(fire_payload);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_idle();
    while (!req_ready) tick();
  endtask

  task automatic send(input int s, input int p, input int d, output logic [31:0] acc);
    bit done;
    done = 1'b0;
    req_valid = 1'b1; req_src = 6'(s); req_payload = 8'(p); req_delay = 16'(d);
    while (!done) begin
      if (req_ready) begin acc = cycle_count; done = 1'b1; end
      tick();
    end
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c;
    int n0, total;
    void'($urandom(32'd4242));
    for (int i = 0; i < NSRC; i++) begin obs_n[i] = 0; obs_at[i] = '0; obs_pay[i] = 0; end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: R1 count 0, R2 ready, R4 no fire, R7 flag low
    compare();

    // R3: plain booking
    send(1, 8'h11, 5, a);
    ticks(10);
    chk("R3 fire time delay 5", obs_at[1], book_cycle(a, 5) + 1);
    chk("R3 payload", obs_pay[1], 8'h11);

    // R3: zero delay behaves as one
    send(2, 8'h22, 0, a);
    ticks(5);
    chk("R3 fire time delay 0", obs_at[2], book_cycle(a, 1) + 1);

    // R5 and R9: three sources aim at one cycle
    send(10, 8'hA0, 20, a);
    send(11, 8'hA1, int'(book_cycle(a, 20) - (cycle_count + 1)), b);
    send(12, 8'hA2, int'(book_cycle(a, 20) - (cycle_count + 1)), c);
    ticks(30);
    chk("R5 older entry keeps cycle", obs_at[10], book_cycle(a, 20) + 1);
    chk("R5 second moved by one", obs_at[11], book_cycle(a, 20) + 2);
    chk("R9 third moved by two", obs_at[12], book_cycle(a, 20) + 3);

    // R6: rebook from one source
    send(7, 8'h70, 50, a);
    send(7, 8'h71, 10, b);
    ticks(70);
    chk("R6 single firing", obs_n[7], 1);
    chk("R6 new payload", obs_pay[7], 8'h71);
    chk("R6 new time", obs_at[7], book_cycle(b, 10) + 1);

    // R8: cancel
    n0 = obs_n[3];
    send(3, 8'h33, 30, a);
    cancel_valid = 1'b1; cancel_src = 6'd3;
    tick();
    cancel_valid = 1'b0;
    ticks(40);
    chk("R8 cancelled never fires", obs_n[3], n0);

    // random mix, checked every cycle against the model
    for (int k = 0; k < 4000; k++) begin
      req_valid = req_ready && ($urandom % 3 == 0);
      req_src = 6'($urandom % 16);
      req_payload = 8'($urandom);
      req_delay = 16'($urandom % 41);
      cancel_valid = ($urandom % 16 == 0);
      cancel_src = 6'($urandom % 16);
      tick();
    end
    req_valid = 1'b0; cancel_valid = 1'b0;
    ticks(100);

    // R7: fill every slot, rebook while full, then overflow
    for (int s = 20; s < 20 + SLOTS; s++) send(s, s, 2000, a);
    send(25, 8'h55, 2100, a);
    chk("R6 rebook while full accepted", overflow, 0);
    send(60, 8'h60, 100, a);
    chk("R7 overflow raised", overflow, 1);
    ticks(2200);
    chk("R7 refused source never fires", obs_n[60], 0);
    total = 0;
    for (int s = 20; s < 20 + SLOTS; s++) total += obs_n[s];
    chk("R7 stored entries all fire", total, SLOTS);
    chk("R6 rebooked payload", obs_pay[25], 8'h55);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule